// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a matrix of up to thirty keys arranged as six drive lines crossing five sense lines. While nothing is pressed the drive lines rest at idle levels. The first sense line seen high starts a scan. A scan drives the enabled lines high one at a time and records which sense lines answer. Every scan makes two full passes over the matrix. The key vector is accepted only when both passes agree, and never sooner than a fixed number of base ticks after the scan began. The block then pulls an active-low request output, which a host answers by reading the vector and pulsing a read-done strobe. That strobe starts another scan. Scanning goes on in this way until a scan agrees on an empty matrix, and then the block returns to idle.

A two-bit sleep setting chooses which drive lines rest high while idle, so that only keys on those lines can wake the block. An oscillator-enable output is low while the block sleeps in idle, and base ticks have no effect then. A two-bit line setting hands the first one or two drive lines over to other use. Those lines are then never driven high, and their keys always read as zero.

Top module: `kmx_scanner`

## Requirements
- R1: After reset the key vector is all zero, the request output reqN is high and the block is idle.
- R2: When idle with sleep setting 00, every enabled drive line is high (driveOut = 6'h3F when all six lines are enabled).
- R3: When idle with a non-zero sleep setting, only these lines rest high: 01 gives line 5 alone, 10 gives lines 5 and 4, and 11 gives lines 5 down to 1. In this state oscEn is low. Reading the key vector does not change the sleep idle pattern.
- R4: Line setting 01 frees line 0, and line setting 1x frees lines 0 and 1. A freed line stays low in every state, and its key bits are captured as zero.
- R5: During a scan, drive lines 0 to 5 are driven high in turn, one per slot. Each slot lasts SCAN_TICKS/6 ticks, and one pass is SCAN_TICKS ticks. If the line of the current slot is freed, no line is high in that slot. A scan makes two passes.
- R6: The sense input j, read while drive line m is high, is stored in key vector bit 5*m + j.
- R7: If both passes agree and at least one key is set, the key vector is loaded and reqN falls on the edge that is REQ_TICKS ticks after the edge that starts the scan. The key vector changes at no other time.
- R8: If the two passes differ, no request is raised and a new scan starts at once.
- R9: reqN is forced high whenever chipEn is high, and a pending request shows again once chipEn falls.
- R10: While a request is pending, read-done releases reqN on the next edge and starts a new scan. The key vector keeps its value. A scan whose passes agree on no keys returns the block to idle without a request.
- R11: In sleep, a press on a line resting low does not start a scan. A press on a line resting high starts a scan, which raises oscEn and scans every enabled line.
- R12: Scan timing advances only on cycles where tick is high, so halving the tick rate doubles the time from scan start to request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base tick enable, one cycle wide |
| senseIn | input | 5 | Sense lines; high means a key answers the line being driven |
| sleepCfg | input | 2 | Sleep setting; 00 means awake |
| lineCfg | input | 2 | Line setting; 00 all lines, 01 frees line 0, 1x frees lines 0 and 1 |
| chipEn | input | 1 | Host transfer in progress; masks the request |
| readDone | input | 1 | One-cycle pulse after the host has read the key vector |
| driveOut | output | 6 | Drive lines, high means driven |
| keyData | output | 30 | Confirmed key vector, bit 5*m+j |
| reqN | output | 1 | Active-low read request |
| oscEn | output | 1 | Oscillator enable, low while sleeping in idle |

## Verification
The assertions assume three things about the inputs. First, sleepCfg and lineCfg change only while the block is idle. Second, readDone is a single-cycle pulse. Third, senseIn follows the drive lines through the key matrix, so sense activity during a scan comes only from the line being driven. The bench meets these by modelling the matrix as a combinational function of driveOut and the set of held keys. It changes the configuration only after a scan has been seen to return to idle, and it drives readDone high for exactly one cycle. Held keys are changed in the middle of a scan only for the test where the two passes are meant to disagree.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  localparam int NUM_DRIVE = 6;
  localparam int NUM_SENSE = 5;
  localparam int NUM_KEYS  = NUM_DRIVE * NUM_SENSE;
  localparam int SLOT_W    = $clog2(NUM_DRIVE);

  // strobes from control to datapath
  typedef struct packed {
    logic              scanDrive;
    logic              idleDrive;
    logic [SLOT_W-1:0] slot;
    logic              pass;
    logic              capture;
    logic              clearBufs;
    logic              commit;
  } kmxStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_PEND} kmxState_t;
endpackage

// File: rtl/kmx_ctrl.sv
module kmx_ctrl
  import kmx_pkg::*;
#(
  parameter int SCAN_TICKS = 384,
  parameter int REQ_TICKS  = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       sleepOn,
  input  logic       chipEn,
  input  logic       readDone,
  input  logic       agree,
  input  logic       anyKey,
  input  logic       anySense,
  output kmxStrobe_t ctl,
  output logic       reqN,
  output logic       oscEn
);
  localparam int SLOT_TICKS = SCAN_TICKS / NUM_DRIVE;
  localparam int CNT_W      = $clog2(REQ_TICKS + 1);
  localparam int TK_W       = $clog2(SLOT_TICKS + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST     = CNT_W'(REQ_TICKS - 1);
  localparam logic [CNT_W-1:0]  CNT_SCAN_END = CNT_W'(2 * SCAN_TICKS);
  localparam logic [TK_W-1:0]   SLOT_LAST    = TK_W'(SLOT_TICKS - 1);
  localparam logic [SLOT_W-1:0] LINE_LAST    = SLOT_W'(NUM_DRIVE - 1);

  kmxState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [TK_W-1:0]   slotTick;
  logic [SLOT_W-1:0] slot;
  logic              pass;

  logic scanning, slotEnd, evalNow, startScan, commitNow;

  always_comb begin
    scanning  = (state == ST_SCAN) && (cnt < CNT_SCAN_END);
    slotEnd   = scanning && tick && (slotTick == SLOT_LAST);
    evalNow   = (state == ST_SCAN) && tick && (cnt == CNT_LAST);
    commitNow = evalNow && agree && anyKey;
    startScan = ((state == ST_IDLE) && anySense) ||
                ((state == ST_PEND) && readDone) ||
                (evalNow && !agree);
  end

  always_comb begin
    ctl.scanDrive = scanning;
    ctl.idleDrive = (state == ST_IDLE);
    ctl.slot      = slot;
    ctl.pass      = pass;
    ctl.capture   = slotEnd;
    ctl.clearBufs = startScan;
    ctl.commit    = commitNow;
    reqN          = (state != ST_PEND) || chipEn;
    oscEn         = !(sleepOn && (state == ST_IDLE));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slotTick <= '0;
      slot     <= '0;
      pass     <= 1'b0;
    end else if (startScan) begin
      state    <= ST_SCAN;
      cnt      <= '0;
      slotTick <= '0;
      slot     <= '0;
      pass     <= 1'b0;
    end else if (evalNow) begin
      state <= commitNow ? ST_PEND : ST_IDLE;
    end else if ((state == ST_SCAN) && tick) begin
      cnt <= cnt + 1'b1;
      if (scanning) begin
        if (slotTick == SLOT_LAST) begin
          slotTick <= '0;
          if (slot == LINE_LAST) begin
            slot <= '0;
            pass <= ~pass;
          end else begin
            slot <= slot + 1'b1;
          end
        end else begin
          slotTick <= slotTick + 1'b1;
        end
      end
    end
  end

  // a pending request survives until the host reports the read
  assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && !readDone) |=> (state == ST_PEND));

  // the block cannot sleep with an unread request
  assert_sleep_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!oscEn && !chipEn) |-> reqN);
endmodule

// File: rtl/kmx_datapath.sv
module kmx_datapath
  import kmx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  kmxStrobe_t           ctl,
  input  logic [NUM_SENSE-1:0] senseIn,
  input  logic [1:0]           sleepCfg,
  input  logic [1:0]           lineCfg,
  output logic [NUM_DRIVE-1:0] driveOut,
  output logic [NUM_KEYS-1:0]  keyData,
  output logic                 agree,
  output logic                 anyKey,
  output logic                 anySense
);
  logic [NUM_DRIVE-1:0] lineEn;
  logic [NUM_DRIVE-1:0] idleMask;
  logic [NUM_DRIVE-1:0] scanSel;
  logic [NUM_KEYS-1:0]  passBuf [2];

  always_comb begin
    lineEn = '1;
    if (lineCfg[1])      lineEn[1:0] = 2'b00;
    else if (lineCfg[0]) lineEn[0]   = 1'b0;
  end

  always_comb begin
    unique case (sleepCfg)
      2'b00:   idleMask = '1;
      2'b01:   idleMask = 6'b100000;
      2'b10:   idleMask = 6'b110000;
      default: idleMask = 6'b111110;
    endcase
  end

  for (genvar m = 0; m < NUM_DRIVE; m++) begin : g_sel
    assign scanSel[m] = (ctl.slot == SLOT_W'(m));
  end

  always_comb begin
    if (ctl.scanDrive)      driveOut = lineEn & scanSel;
    else if (ctl.idleDrive) driveOut = lineEn & idleMask;
    else                    driveOut = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearBufs) begin
      passBuf[0] <= '0;
      passBuf[1] <= '0;
    end else if (ctl.capture) begin
      for (int m = 0; m < NUM_DRIVE; m++) begin
        if (scanSel[m])
          passBuf[ctl.pass][m*NUM_SENSE +: NUM_SENSE] <= lineEn[m] ? senseIn : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           keyData <= '0;
    else if (ctl.commit) keyData <= passBuf[0];
  end

  assign agree    = (passBuf[0] == passBuf[1]);
  assign anyKey   = |passBuf[0];
  assign anySense = |senseIn;

  assert_one_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.scanDrive |-> $onehot0(driveOut));

  assert_capture_in_scan_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> ctl.scanDrive);

  assert_freed_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lineCfg != 2'b00) |-> !driveOut[0]);

  assert_keys_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(keyData));
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
  import kmx_pkg::*;
#(
  parameter int SCAN_TICKS = 384,
  parameter int REQ_TICKS  = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [4:0] senseIn,
  input  logic [1:0] sleepCfg,
  input  logic [1:0] lineCfg,
  input  logic       chipEn,
  input  logic       readDone,
  output logic [5:0] driveOut,
  output logic [29:0] keyData,
  output logic       reqN,
  output logic       oscEn
);
  kmxStrobe_t ctl;
  logic agree, anyKey, anySense;

  kmx_ctrl #(.SCAN_TICKS(SCAN_TICKS), .REQ_TICKS(REQ_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .sleepOn(|sleepCfg),
    .chipEn(chipEn), .readDone(readDone), .agree(agree), .anyKey(anyKey),
    .anySense(anySense), .ctl(ctl), .reqN(reqN), .oscEn(oscEn)
  );

  kmx_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .senseIn(senseIn),
    .sleepCfg(sleepCfg), .lineCfg(lineCfg), .driveOut(driveOut),
    .keyData(keyData), .agree(agree), .anyKey(anyKey), .anySense(anySense)
  );
endmodule

// File: tb/kmx_scanner_tb.sv
module kmx_scanner_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, tick, chipEn, readDone, halfRate;
  logic [1:0]  sleepCfg, lineCfg;
  logic [29:0] pressed;
  logic [4:0]  senseIn;
  logic [5:0]  driveOut;
  logic [29:0] keyData;
  logic        reqN, oscEn;

  int checks = 0;
  int errors = 0;
  logic [29:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kmx_scanner u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .senseIn(senseIn),
    .sleepCfg(sleepCfg), .lineCfg(lineCfg), .chipEn(chipEn),
    .readDone(readDone), .driveOut(driveOut), .keyData(keyData),
    .reqN(reqN), .oscEn(oscEn)
  );

  // key matrix model: sense j answers when a held key sits on a driven line
  always_comb begin
    senseIn = '0;
    for (int m = 0; m < 6; m++)
      for (int j = 0; j < 5; j++)
        if (pressed[m*5+j] && driveOut[m]) senseIn[j] = 1'b1;
  end

  initial begin
    tick = 1'b1;
    forever begin
      @(negedge clk);
      tick = halfRate ? ~tick : 1'b1;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pressExpect(input logic [29:0] keys, input logic [29:0] exp);
    expQ.push_back(exp);
    pressed = keys;
  endtask

  task automatic readRelease(input logic [5:0] idlePat);
    pressed  = '0;
    readDone = 1'b1;
    step(1);
    readDone = 1'b0;
    step(800);
    chk(reqN == 1'b1, "R10 no request on empty scan", reqN, 1);
    chk(driveOut == idlePat, "R10 back to idle", driveOut, idlePat);
  endtask

  // scoreboard monitor: compare key vector on each fresh request
  initial begin
    logic prevReqN = 1'b1;
    logic prevCe   = 1'b0;
    forever begin
      @(negedge clk);
      #4;
      if (rstN === 1'b1 && prevReqN && !reqN && !prevCe) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected request actual=%0h expected=none", keyData);
        end else begin
          logic [29:0] e;
          e = expQ.pop_front();
          chk(keyData == e, "R6 R7 key vector", keyData, e);
        end
      end
      prevReqN = reqN;
      prevCe   = chipEn;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; halfRate = 1'b0; chipEn = 1'b0; readDone = 1'b0;
    sleepCfg = 2'b00; lineCfg = 2'b00; pressed = '0;
    step(3);
    rstN = 1'b1;
    step(1);
    chk(keyData == '0, "R1 keys zero", keyData, 0);
    chk(reqN == 1'b1, "R1 request idle", reqN, 1);
    chk(driveOut == 6'h3F, "R2 idle all high", driveOut, 6'h3F);
    chk(oscEn == 1'b1, "R3 awake osc", oscEn, 1);

    // basic press, key on line 0 sense 2
    pressExpect(30'h1 << 2, 30'h1 << 2);
    step(1);
    chk(driveOut == 6'b000001, "R5 slot 0", driveOut, 6'b000001);
    step(64);
    chk(driveOut == 6'b000010, "R5 slot 1", driveOut, 6'b000010);
    step(735);
    chk(reqN == 1'b1, "R7 not before window", reqN, 1);
    step(1);
    chk(reqN == 1'b0, "R7 request at window", reqN, 0);
    step(1);

    // chip enable masking
    chipEn = 1'b1; #1;
    chk(reqN == 1'b1, "R9 masked", reqN, 1);
    #1 chipEn = 1'b0; #1;
    chk(reqN == 1'b0, "R9 unmasked", reqN, 0);

    // read with key still held
    expQ.push_back(30'h1 << 2);
    step(1);
    readDone = 1'b1;
    step(1);
    readDone = 1'b0;
    chk(reqN == 1'b1, "R10 released", reqN, 1);
    chk(keyData == (30'h1 << 2), "R10 keys held", keyData, 30'h1 << 2);
    step(799);
    chk(reqN == 1'b1, "R10 rescan window", reqN, 1);
    step(1);
    chk(reqN == 1'b0, "R10 rescan request", reqN, 0);
    readRelease(6'h3F);
    chk(keyData == (30'h1 << 2), "R10 keys kept after empty scan", keyData, 30'h1 << 2);

    // two keys on distant lines
    pressExpect((30'h1 << 15) | (30'h1 << 29), (30'h1 << 15) | (30'h1 << 29));
    step(801);
    chk(reqN == 1'b0, "R6 multi key request", reqN, 0);
    readRelease(6'h3F);

    // disagreement between passes
    expQ.push_back(30'h1 << 17);
    pressed = 30'h1 << 0;
    step(400);
    pressed = 30'h1 << 17;
    step(401);
    chk(reqN == 1'b1, "R8 no request on mismatch", reqN, 1);
    step(800);
    chk(reqN == 1'b0, "R8 request after rescan", reqN, 0);
    readRelease(6'h3F);

    // freed lines
    lineCfg = 2'b01;
    step(1);
    chk(driveOut == 6'b111110, "R4 line 0 freed idle", driveOut, 6'b111110);
    pressExpect((30'h1 << 1) | (30'h1 << 11), 30'h1 << 11);
    step(1);
    chk(driveOut == 6'b000000, "R4 freed slot silent", driveOut, 0);
    step(800);
    chk(reqN == 1'b0, "R4 request", reqN, 0);
    readRelease(6'b111110);
    lineCfg = 2'b10;
    step(1);
    chk(driveOut == 6'b111100, "R4 two lines freed", driveOut, 6'b111100);
    lineCfg = 2'b00;

    // sleep
    sleepCfg = 2'b01;
    step(1);
    chk(driveOut == 6'b100000, "R3 sleep 01 pattern", driveOut, 6'b100000);
    chk(oscEn == 1'b0, "R3 osc off", oscEn, 0);
    pressed = 30'h1 << 6;
    step(20);
    chk(driveOut == 6'b100000, "R11 low line ignored", driveOut, 6'b100000);
    chk(reqN == 1'b1, "R11 no request", reqN, 1);
    pressExpect((30'h1 << 6) | (30'h1 << 27), (30'h1 << 6) | (30'h1 << 27));
    step(1);
    chk(oscEn == 1'b1, "R11 wake osc", oscEn, 1);
    chk(driveOut == 6'b000001, "R11 full scan", driveOut, 6'b000001);
    step(800);
    chk(reqN == 1'b0, "R11 request", reqN, 0);
    readRelease(6'b100000);
    chk(oscEn == 1'b0, "R3 still asleep after read", oscEn, 0);
    sleepCfg = 2'b11;
    step(1);
    chk(driveOut == 6'b111110, "R3 sleep 11 pattern", driveOut, 6'b111110);
    sleepCfg = 2'b10;
    step(1);
    chk(driveOut == 6'b110000, "R3 sleep 10 pattern", driveOut, 6'b110000);
    sleepCfg = 2'b00;
    step(1);

    // half tick rate
    halfRate = 1'b1;
    pressExpect(30'h1 << 3, 30'h1 << 3);
    step(1590);
    chk(reqN == 1'b1, "R12 slowed window", reqN, 1);
    step(14);
    chk(reqN == 1'b0, "R12 slowed request", reqN, 0);
    halfRate = 1'b0;
    step(1);
    readRelease(6'h3F);

    step(2);
    chk(expQ.size() == 0, "R7 all expected requests seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule